// File: doc/BRIEF.md
# Serial-Programmed 4x4 Crosspoint Route Controller

This block holds the routing state of a four-input, four-output crosspoint. Programming arrives as a serial bit stream clocked by a slow serial clock (`ser_clk`). The block samples that clock with its own system clock and shifts one data bit on each rising serial edge. Every 16 bits form a frame. A frame holds four 2-bit input indices, one per output, followed by a column and a row address. A frame whose addresses are both zero is addressed to this device. Its routing part is kept in a load register. A separate load strobe then moves it into the live configuration, so all four outputs switch at once.

Devices can be chained. The block drives a column stream and a row stream to its neighbours, each with a clock copy. Each stream carries the incoming frames, one frame late. The column address is reduced by one on the column stream and the row address on the row stream, so each device down the chain sees the frame meant for it at address zero.

A preset input moves the block into a fixed-route mode. In that mode the serial clock is blocked internally and two select pins choose one of four hardwired routings. The high-speed data path is not part of this block. Its output is the 2-bit input index for each output.

Top module: `xpt_serial_ctrl`

## Requirements
- R1: After reset, with `mode` low, `route_sel` is the identity routing 8'hE4. The field `route_sel[2n+1:2n]` holds the index of the input driving output n+1, and index v means input v+1.
- R2: With `mode` and `load` low, each rising `ser_clk` edge shifts `sel1_sdi` into the frame, MSB first. Frame bits [15:14] are the index for output 1, [13:12] for output 2, [11:10] for output 3 and [9:8] for output 4. Bits [7:4] are the column address and [3:0] the row address. Frames align on 16-bit boundaries counted from reset.
- R3: A completed frame is stored in the load register only when both address fields are zero. A frame with any non-zero address leaves the load register unchanged, and a later load shows the previously stored routing.
- R4: A rising `ser_clk` edge with `load` high and `mode` low copies the load register into the configuration, and all four fields of `route_sel` change together. Further edges with `load` held high leave the routing the same.
- R5: A load edge before any valid frame has been received since reset leaves `route_sel` unchanged.
- R6: `casc_sdo_col` carries the input stream delayed by 16 data edges, with the column field of each frame reduced by one modulo 16. Before the first forwarded frame it carries the filler frame 16'h1BFF: identity routing with all address bits set.
- R7: `casc_sdo_row` is the same stream with the row field reduced by one modulo 16 instead, and starts with the same filler frame.
- R8: `casc_clk_col` and `casc_clk_row` follow `ser_clk` while `mode` is low and are held low while `mode` is high.
- R9: With `mode` high, `route_sel` is set by {`sel1_sdi`,`sel0`}: 00 gives 8'h00 (input 1 to all outputs), 01 gives 8'h55 (input 2 to all), 10 gives 8'hA0 (input 1 to outputs 1-2, input 3 to outputs 3-4) and 11 gives 8'hE4 (one to one).
- R10: While `mode` is high, serial edges are ignored. No bit is shifted, no load happens and the cascade data outputs hold their values.
- R11: With `mode` low, `route_sel` shows the configuration and does not depend on `sel0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial programming clock |
| sel1_sdi | input | 1 | Serial data when `mode` is low; upper preset select when high |
| sel0 | input | 1 | Lower preset select |
| load | input | 1 | Load strobe sampled on serial edges |
| mode | input | 1 | High selects preset routing and blocks the serial clock |
| route_sel | output | 8 | Four 2-bit input indices, output 1 in bits [1:0] |
| casc_sdo_col | output | 1 | Forwarded stream with column address reduced by one |
| casc_sdo_row | output | 1 | Forwarded stream with row address reduced by one |
| casc_clk_col | output | 1 | Serial clock copy for the column chain |
| casc_clk_row | output | 1 | Serial clock copy for the row chain |

## Verification
A rising `ser_clk` is first caught by one sampling register and then acted on at the following `clk` edge. The configuration, `route_sel` in configured mode and each cascade data bit are therefore due two `clk` cycles after the serial clock rises. The preset routing and the cascade clocks follow their inputs in the same cycle. The bench holds each serial clock phase for four `clk` cycles and checks only after the whole bit has gone by, sampling at falling `clk` edges. Each check is made against a bench model that updates once per serial bit.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int unsigned N_OUT   = 4;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned CFG_W   = N_OUT * SEL_W;
  localparam int unsigned FRAME_W = CFG_W + 2 * ADDR_W;
  localparam int unsigned POS_W   = $clog2(FRAME_W);

  typedef logic [CFG_W-1:0]   route_t;
  typedef logic [FRAME_W-1:0] frame_t;

  // Extract per-output indices; output 1 is at the frame MSB end.
  function automatic route_t frame_route(input frame_t f);
    route_t r;
    for (int n = 0; n < N_OUT; n++)
      r[n*SEL_W +: SEL_W] = f[FRAME_W-1-n*SEL_W -: SEL_W];
    return r;
  endfunction

  function automatic logic frame_addr_zero(input frame_t f);
    return f[2*ADDR_W-1:0] == '0;
  endfunction

  // Reduce the column (row_chain=0) or row (row_chain=1) field by one.
  function automatic frame_t frame_dec(input frame_t f, input logic row_chain);
    frame_t o;
    o = f;
    if (row_chain) o[ADDR_W-1:0] = f[ADDR_W-1:0] - 1'b1;
    else           o[2*ADDR_W-1:ADDR_W] = f[2*ADDR_W-1:ADDR_W] - 1'b1;
    return o;
  endfunction

  function automatic route_t ident_route();
    route_t r;
    for (int n = 0; n < N_OUT; n++) r[n*SEL_W +: SEL_W] = SEL_W'(n);
    return r;
  endfunction

  // Identity routing with all address bits set: addressed to no device.
  function automatic frame_t filler_frame();
    frame_t f;
    f = '1;
    for (int n = 0; n < N_OUT; n++) f[FRAME_W-1-n*SEL_W -: SEL_W] = SEL_W'(n);
    return f;
  endfunction

  function automatic route_t preset_route(input logic [1:0] sel);
    route_t r;
    for (int n = 0; n < N_OUT; n++) begin
      unique case (sel)
        2'b00: r[n*SEL_W +: SEL_W] = SEL_W'(0);
        2'b01: r[n*SEL_W +: SEL_W] = SEL_W'(1);
        2'b10: r[n*SEL_W +: SEL_W] = (n < N_OUT/2) ? SEL_W'(0) : SEL_W'(2);
        default: r[n*SEL_W +: SEL_W] = SEL_W'(n);
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/xpt_sclk_sampler.sv
module xpt_sclk_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic sdi,
  input  logic load,
  input  logic mode,
  output logic sdi_q,
  output logic data_evt,
  output logic load_evt
);
  logic sclk_s1, sclk_s2, load_q, rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_s1 <= 1'b0;
      sclk_s2 <= 1'b0;
      sdi_q   <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      sclk_s1 <= ser_clk & ~mode;   // internal clock held low in preset mode
      sclk_s2 <= sclk_s1;
      sdi_q   <= sdi;
      load_q  <= load;
    end
  end

  assign rise     = sclk_s1 & ~sclk_s2;
  assign data_evt = rise & ~load_q;
  assign load_evt = rise & load_q;

  p_mode_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode) |-> !data_evt && !load_evt);
endmodule

// File: rtl/xpt_frame_rx.sv
module xpt_frame_rx
  import xpt_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sdi_q,
  input  logic   data_evt,
  input  logic   load_evt,
  output logic   frame_last,
  output route_t cfg_q
);
  localparam int unsigned LAST = FRAME_W - 1;

  logic [FRAME_W-2:0] sr_q;
  logic [POS_W-1:0]   pos_q;
  route_t             ldr_q;
  logic               valid_q;
  frame_t             frame_nxt;

  assign frame_nxt  = {sr_q, sdi_q};
  assign frame_last = (pos_q == POS_W'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= filler_frame()[FRAME_W-2:0];
      pos_q   <= '0;
      ldr_q   <= ident_route();
      valid_q <= 1'b0;
      cfg_q   <= ident_route();
    end else begin
      if (data_evt) begin
        sr_q  <= frame_nxt[FRAME_W-2:0];
        pos_q <= frame_last ? '0 : pos_q + 1'b1;
        if (frame_last && frame_addr_zero(frame_nxt)) begin
          ldr_q   <= frame_route(frame_nxt);
          valid_q <= 1'b1;
        end
      end
      if (load_evt && valid_q) cfg_q <= ldr_q;
    end
  end

  p_pos_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_evt && frame_last |=> pos_q == '0);
  p_valid_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> valid_q);
  p_load_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && valid_q |=> cfg_q == $past(ldr_q));
  p_early_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt && !valid_q |=> $stable(cfg_q));
endmodule

// File: rtl/xpt_casc_line.sv
module xpt_casc_line
  import xpt_pkg::*;
#(
  parameter bit ROW_CHAIN = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sdi_q,
  input  logic data_evt,
  input  logic frame_last,
  output logic sdo
);
  frame_t line_q, line_nxt;

  assign line_nxt = {line_q[FRAME_W-2:0], sdi_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= filler_frame();
      sdo    <= 1'b0;
    end else if (data_evt) begin
      sdo    <= line_q[FRAME_W-1];
      line_q <= frame_last ? frame_dec(line_nxt, ROW_CHAIN) : line_nxt;
    end
  end

  p_line_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !data_evt |=> $stable(sdo));
endmodule

// File: rtl/xpt_serial_ctrl.sv
module xpt_serial_ctrl
  import xpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             sel1_sdi,
  input  logic             sel0,
  input  logic             load,
  input  logic             mode,
  output logic [CFG_W-1:0] route_sel,
  output logic             casc_sdo_col,
  output logic             casc_sdo_row,
  output logic             casc_clk_col,
  output logic             casc_clk_row
);
  logic   sdi_q, data_evt, load_evt, frame_last;
  route_t cfg_q;
  logic [1:0] sdo_w;

  xpt_sclk_sampler u_samp (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .sdi(sel1_sdi),
    .load(load), .mode(mode), .sdi_q(sdi_q), .data_evt(data_evt),
    .load_evt(load_evt)
  );

  xpt_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sdi_q(sdi_q), .data_evt(data_evt),
    .load_evt(load_evt), .frame_last(frame_last), .cfg_q(cfg_q)
  );

  for (genvar g = 0; g < 2; g++) begin : g_chain
    xpt_casc_line #(.ROW_CHAIN(g[0])) u_line (
      .clk(clk), .rst_n(rst_n), .sdi_q(sdi_q), .data_evt(data_evt),
      .frame_last(frame_last), .sdo(sdo_w[g])
    );
  end

  assign casc_sdo_col = sdo_w[0];
  assign casc_sdo_row = sdo_w[1];
  assign casc_clk_col = ser_clk & ~mode;
  assign casc_clk_row = ser_clk & ~mode;
  assign route_sel    = mode ? preset_route({sel1_sdi, sel0}) : cfg_q;

  p_cfg_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(cfg_q));
endmodule

// File: tb/test_xpt_serial_ctrl.sv
module test_xpt_serial_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, sel1_sdi = 1'b0, sel0 = 1'b0, load = 1'b0, mode = 1'b0;
  logic [7:0] route_sel;
  logic casc_sdo_col, casc_sdo_row, casc_clk_col, casc_clk_row;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [15:0] sh_m;
  int          pos_m = 0;
  logic [7:0]  ldr_m = 8'hE4, cfg_m = 8'hE4;
  bit          vld_m = 0;
  logic [15:0] ocol_m = 16'h1BFF, orow_m = 16'h1BFF;

  always #4 clk = ~clk;

  xpt_serial_ctrl i_xpt_serial_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .sel1_sdi(sel1_sdi),
    .sel0(sel0), .load(load), .mode(mode), .route_sel(route_sel),
    .casc_sdo_col(casc_sdo_col), .casc_sdo_row(casc_sdo_row),
    .casc_clk_col(casc_clk_col), .casc_clk_row(casc_clk_row)
  );

  function automatic logic [15:0] b_frame(logic [7:0] r, logic [3:0] c, logic [3:0] w);
    return {r[1:0], r[3:2], r[5:4], r[7:6], c, w};
  endfunction
  function automatic logic [7:0] b_route(logic [15:0] f);
    return {f[9:8], f[11:10], f[13:12], f[15:14]};
  endfunction
  function automatic logic [7:0] b_preset(logic [1:0] s);
    case (s)
      2'b00: return 8'h00;
      2'b01: return 8'h55;
      2'b10: return 8'hA0;
      default: return 8'hE4;
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic sbit(logic b, logic ld);
    logic pc, pr, ec, er;
    pc = casc_sdo_col; pr = casc_sdo_row;
    @(negedge clk); sel1_sdi = b; load = ld; ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    if (mode) begin
      chk("R10 col hold", {15'd0, casc_sdo_col}, {15'd0, pc});
      chk("R10 row hold", {15'd0, casc_sdo_row}, {15'd0, pr});
    end else if (!ld) begin
      ec = ocol_m[15-pos_m]; er = orow_m[15-pos_m];
      sh_m = {sh_m[14:0], b};
      if (pos_m == 15) begin
        if (sh_m[7:0] == 8'h00) begin ldr_m = b_route(sh_m); vld_m = 1; end
        ocol_m = {sh_m[15:8], sh_m[7:4] - 4'd1, sh_m[3:0]};
        orow_m = {sh_m[15:4], sh_m[3:0] - 4'd1};
        pos_m = 0;
      end else pos_m++;
      chk("R6 col stream", {15'd0, casc_sdo_col}, {15'd0, ec});
      chk("R7 row stream", {15'd0, casc_sdo_row}, {15'd0, er});
    end else if (vld_m) cfg_m = ldr_m;
  endtask

  task automatic send(logic [7:0] r, logic [3:0] c, logic [3:0] w);
    logic [15:0] f;
    f = b_frame(r, c, w);
    for (int i = 15; i >= 0; i--) sbit(f[i], 1'b0);
  endtask

  initial begin
    logic [7:0] r;
    logic [3:0] c, w;
    int unsigned k;
    k = $urandom(32'h00C0FFEE);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset route", {8'd0, route_sel}, 16'h00E4);
    chk("R8 clk low idle", {14'd0, casc_clk_col, casc_clk_row}, 16'd0);

    // R5: load before any valid frame
    sbit(1'b0, 1'b1);
    chk("R5 early load", {8'd0, route_sel}, 16'h00E4);

    // R8: clock copies
    ser_clk = 1'b1; @(negedge clk);
    chk("R8 clk follow", {14'd0, casc_clk_col, casc_clk_row}, 16'h0003);
    mode = 1'b1; @(negedge clk);
    chk("R8 clk gated", {14'd0, casc_clk_col, casc_clk_row}, 16'd0);
    ser_clk = 1'b0; @(negedge clk); mode = 1'b0;
    repeat (3) @(negedge clk);

    // R3: frame to another device, then load
    send(8'h1B, 4'h1, 4'h0);
    sbit(1'b0, 1'b1);
    chk("R3 misaddressed", {8'd0, route_sel}, {8'd0, cfg_m});
    chk("R3 still identity", {8'd0, route_sel}, 16'h00E4);

    // R4: valid frame, not live until load; held load repeats
    send(8'h4E, 4'h0, 4'h0);
    chk("R4 before load", {8'd0, route_sel}, 16'h00E4);
    sbit(1'b0, 1'b1);
    chk("R4 after load", {8'd0, route_sel}, 16'h004E);
    sbit(1'b1, 1'b1); sbit(1'b0, 1'b1);
    chk("R4 held load", {8'd0, route_sel}, 16'h004E);

    // R11: sel0 has no effect with mode low
    sel0 = 1'b1; @(negedge clk);
    chk("R11 sel0 ignored", {8'd0, route_sel}, {8'd0, cfg_m});
    sel0 = 1'b0;

    // R9 presets
    mode = 1'b1;
    for (int s = 0; s < 4; s++) begin
      sel1_sdi = s[1]; sel0 = s[0]; @(negedge clk);
      chk("R9 preset", {8'd0, route_sel}, {8'd0, b_preset(s[1:0])});
    end

    // R10: edges in preset mode ignored (data and load)
    for (int i = 0; i < 7; i++) sbit(i[0], 1'b0);
    sbit(1'b1, 1'b1);
    sel1_sdi = 1'b0; sel0 = 1'b0;
    @(negedge clk); mode = 1'b0; @(negedge clk);
    chk("R10 config kept", {8'd0, route_sel}, {8'd0, cfg_m});

    // Random frames with occasional loads and preset excursions
    for (int it = 0; it < 40; it++) begin
      r = 8'($urandom);
      k = $urandom % 5;
      c = (k == 0 || k == 1) ? 4'h0 : (k == 2) ? 4'h1 : (k == 3) ? 4'hF : 4'($urandom);
      k = $urandom % 4;
      w = (k < 2) ? 4'h0 : (k == 2) ? 4'h1 : 4'($urandom);
      send(r, c, w);
      chk("R2 no change w/o load", {8'd0, route_sel}, {8'd0, cfg_m});
      if ($urandom % 2 == 1) begin
        sbit(1'($urandom), 1'b1);
        chk("R4 random load", {8'd0, route_sel}, {8'd0, cfg_m});
      end
      if ($urandom % 6 == 0) begin
        mode = 1'b1;
        for (int i = 0; i < 3; i++) sbit(1'($urandom), 1'($urandom));
        sel1_sdi = 1'b1; sel0 = 1'b0; @(negedge clk);
        chk("R9 random preset", {8'd0, route_sel}, 16'h00A0);
        sel1_sdi = 1'b0; @(negedge clk); mode = 1'b0; @(negedge clk);
        chk("R10 random resume", {8'd0, route_sel}, {8'd0, cfg_m});
      end
    end

    // R3: after a valid frame, a later misaddressed frame must not replace it
    send(8'h1E, 4'h0, 4'h0);
    send(8'hB1, 4'h0, 4'h2);
    sbit(1'b0, 1'b1);
    chk("R3 last valid kept", {8'd0, route_sel}, 16'h001E);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule